// File: doc/BRIEF.md
# Masked Interrupt Pin Router

This block turns nine status flags, taken from two 16-bit status words, into a single interrupt request. Each flag has a mask bit at the same position of a companion mask word. The request goes out on one of four interrupt pins. A select register chooses the pin. Each pin has its own output-enable, so the three pins that are not chosen float. Software or a configuration loader sets the polarity of the active level. It also chooses between a level signal that follows the request and a one-clock pulse on each new request.

After reset every pin floats. The pins stay floating until the configuration loader reports a good load. After a failed load they can also be enabled when a relocation sequence reports completion. Once enabled, the pins stay enabled until the next reset. The status, mask and configuration inputs are plain control signals sampled on every clock. There is no streaming data path, so no valid/ready handshake is involved.

Top module: `irq_pin_router`

## Requirements
- R1: The request sources are status-A bits 14, 12, 11, 10 and 8, and status-B bits 9, 5, 3 and 1. A source is pending when its status bit is 1 and the mask bit at the same position of its mask word is 0. Any other bit position of either status or mask word has no effect on the pins.
- R2: A source whose mask bit is 1 never makes the selected pin active, and neither does a mask bit set at some other position.
- R3: Once enabled, exactly one bit of `irq_oe` is 1, at index `sel` (value 0 selects pin 1 at index 0, value 3 selects pin 4 at index 3).
- R4: The select register resets to 0, so pin 1 is chosen unless it is rewritten. The register loads `sel_in` on a clock edge where `sel_wr` is 1. The new pin takes over after that same edge and shows the current request state.
- R5: Every pin whose enable is 0 drives the inactive level, which is the complement of `pol_hi` (reset state: all pins 0).
- R6: The active level is 1 when `pol_hi` is 1 and 0 when `pol_hi` is 0.
- R7: When `edge_mode` is 0, the selected pin is active after each edge at which any source was pending, and inactive after each edge at which none was.
- R8: When `edge_mode` is 1, the selected pin is active for exactly one cycle after an edge where the request is seen pending and it was not pending at the previous edge. The request counts as not pending during reset. While the request stays pending, the pin stays inactive.
- R9: During and after reset every bit of `irq_oe` is 0. Enables turn on after the edge that samples `cfg_ok` high. They also turn on after an edge that samples `reloc_done` high, provided an earlier edge has sampled `cfg_fail` high, and `cfg_ok` also arms in that state. If `cfg_ok` and `cfg_fail` are high together, `cfg_ok` wins.
- R10: `reloc_done` before any `cfg_fail` is ignored. Once the enables are on, `cfg_ok`, `cfg_fail` and `reloc_done` have no further effect until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stat_a | input | 16 | Status word A (sources at bits 14,12,11,10,8) |
| stat_b | input | 16 | Status word B (sources at bits 9,5,3,1) |
| mask_a | input | 16 | Mask word for status A, 1 blocks the source |
| mask_b | input | 16 | Mask word for status B, 1 blocks the source |
| sel_in | input | 2 | New pin selection |
| sel_wr | input | 1 | Load strobe for the select register |
| pol_hi | input | 1 | 1: active-high pins, 0: active-low |
| edge_mode | input | 1 | 0: level signalling, 1: one-clock pulse per new request |
| cfg_ok | input | 1 | Configuration load succeeded |
| cfg_fail | input | 1 | Configuration load failed |
| reloc_done | input | 1 | Recovery relocation sequence completed |
| irq_pin | output | 4 | Pin values, index 0 is pin 1 |
| irq_oe | output | 4 | Pin output-enables, 1 drives the pin |

## Verification
The hardest situation to reach is the recovery path to enabled pins. It needs a failed load and then a relocation completion, and it must not be fooled by a relocation completion that arrives first. The stimulus pulses `reloc_done` before any failure while a source is pending, to show the pins still float. It then pulses `cfg_fail`, waits idle cycles and finally pulses `reloc_done`. A second reset covers the direct `cfg_ok` path. The pulse behaviour in edge mode is reached by holding a source pending across several cycles, and by moving the select register while the request is held.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  // Width of each status / mask word.
  localparam int STAT_W = 16;
  // Number of interrupt sources in each word.
  localparam int NUM_A  = 5;
  localparam int NUM_B  = 4;

  typedef enum logic [1:0] {
    ARM_WAIT = 2'd0,   // floating, no load result yet
    ARM_FAIL = 2'd1,   // floating, load failed, waiting for recovery
    ARM_LIVE = 2'd2    // pins driven
  } arm_state_e;

  // Bit position of source i in status word A.
  function automatic int pos_a(input int i);
    case (i)
      0:       return 14;
      1:       return 12;
      2:       return 11;
      3:       return 10;
      default: return 8;
    endcase
  endfunction

  // Bit position of source i in status word B.
  function automatic int pos_b(input int i);
    case (i)
      0:       return 9;
      1:       return 5;
      2:       return 3;
      default: return 1;
    endcase
  endfunction

  function automatic logic [STAT_W-1:0] src_sel_a();
    logic [STAT_W-1:0] v;
    v = '0;
    for (int i = 0; i < NUM_A; i++) v[pos_a(i)] = 1'b1;
    return v;
  endfunction

  function automatic logic [STAT_W-1:0] src_sel_b();
    logic [STAT_W-1:0] v;
    v = '0;
    for (int i = 0; i < NUM_B; i++) v[pos_b(i)] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/irq_src_combiner.sv
// Masks each source and ORs the survivors into one request (R1, R2).
module irq_src_combiner
  import irq_router_pkg::*;
(
  input  logic [STAT_W-1:0] stat_a,
  input  logic [STAT_W-1:0] stat_b,
  input  logic [STAT_W-1:0] mask_a,
  input  logic [STAT_W-1:0] mask_b,
  output logic              req_any
);

  localparam logic [STAT_W-1:0] SRC_A = src_sel_a();
  localparam logic [STAT_W-1:0] SRC_B = src_sel_b();

  logic [STAT_W-1:0] live_a;
  logic [STAT_W-1:0] live_b;

  // One gate per bit position; non-source positions are tied off by SRC_x.
  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    assign live_a[b] = SRC_A[b] & stat_a[b] & ~mask_a[b];
    assign live_b[b] = SRC_B[b] & stat_b[b] & ~mask_b[b];
  end

  assign req_any = (|live_a) | (|live_b);

endmodule

// File: rtl/irq_shaper.sv
// Level pass-through or rising-edge pulse of the combined request (R7, R8).
module irq_shaper (
  input  logic clk,
  input  logic rst_n,
  input  logic req_any,
  input  logic edge_mode,
  output logic shaped_nx
);

  logic req_prev_q;
  logic pulse_q;
  logic mode_q;

  // Value the pin takes at the coming edge.
  assign shaped_nx = req_any & (~edge_mode | ~req_prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_prev_q <= 1'b0;
      pulse_q    <= 1'b0;
      mode_q     <= 1'b0;
    end else begin
      req_prev_q <= req_any;
      pulse_q    <= shaped_nx;
      mode_q     <= edge_mode;
    end
  end

  // R8: in edge mode an active cycle is never followed by another one.
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && pulse_q) |=> !(mode_q && pulse_q));

endmodule

// File: rtl/irq_arm_ctrl.sv
// Keeps the pins floating until a load or recovery result arrives (R9, R10).
module irq_arm_ctrl
  import irq_router_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_ok,
  input  logic cfg_fail,
  input  logic reloc_done,
  output logic arm_nx,
  output logic arm_q
);

  arm_state_e state_q, state_nx;

  always_comb begin
    state_nx = state_q;
    unique case (state_q)
      ARM_WAIT: begin
        if (cfg_ok)        state_nx = ARM_LIVE;
        else if (cfg_fail) state_nx = ARM_FAIL;
      end
      ARM_FAIL: begin
        if (cfg_ok || reloc_done) state_nx = ARM_LIVE;
      end
      ARM_LIVE: state_nx = ARM_LIVE;
      default:  state_nx = ARM_WAIT;
    endcase
  end

  assign arm_nx = (state_nx == ARM_LIVE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARM_WAIT;
      arm_q   <= 1'b0;
    end else begin
      state_q <= state_nx;
      arm_q   <= arm_nx;
    end
  end

  // R10: relocation completion without a prior failure does not arm.
  p_reloc_needs_fail_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ARM_WAIT && !cfg_ok) |=> !arm_q);

  // R10: armed state is kept until reset.
  p_live_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    arm_q |=> arm_q);

endmodule

// File: rtl/irq_pin_steer.sv
// Select register, per-pin enable and polarity (R3, R4, R5, R6).
module irq_pin_steer #(
  parameter int NUM_PINS = 4,
  localparam int SEL_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SEL_W-1:0]    sel_in,
  input  logic                sel_wr,
  input  logic                arm_nx,
  input  logic                shaped_nx,
  input  logic                pol_hi,
  output logic [NUM_PINS-1:0] pin,
  output logic [NUM_PINS-1:0] oe
);

  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] sel_nx;

  // A write is visible at the same edge that stores it.
  assign sel_nx = sel_wr ? sel_in : sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_nx;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic hit;
    logic oe_r;
    logic pin_r;

    assign hit = arm_nx & (sel_nx == SEL_W'(p));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        oe_r  <= 1'b0;
        pin_r <= 1'b0;
      end else begin
        oe_r  <= hit;
        pin_r <= (hit & shaped_nx) ? pol_hi : ~pol_hi;
      end
    end

    assign oe[p]  = oe_r;
    assign pin[p] = pin_r;
  end

  // R3: never more than one driven pin.
  p_oe_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(oe));

endmodule

// File: rtl/irq_pin_router.sv
module irq_pin_router
  import irq_router_pkg::*;
#(
  parameter int NUM_PINS = 4,
  localparam int SEL_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [STAT_W-1:0]   stat_a,
  input  logic [STAT_W-1:0]   stat_b,
  input  logic [STAT_W-1:0]   mask_a,
  input  logic [STAT_W-1:0]   mask_b,
  input  logic [SEL_W-1:0]    sel_in,
  input  logic                sel_wr,
  input  logic                pol_hi,
  input  logic                edge_mode,
  input  logic                cfg_ok,
  input  logic                cfg_fail,
  input  logic                reloc_done,
  output logic [NUM_PINS-1:0] irq_pin,
  output logic [NUM_PINS-1:0] irq_oe
);

  logic req_any;
  logic shaped_nx;
  logic arm_nx;
  logic arm_q;

  irq_src_combiner u_comb (
    .stat_a  (stat_a),
    .stat_b  (stat_b),
    .mask_a  (mask_a),
    .mask_b  (mask_b),
    .req_any (req_any)
  );

  irq_shaper u_shape (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_any   (req_any),
    .edge_mode (edge_mode),
    .shaped_nx (shaped_nx)
  );

  irq_arm_ctrl u_arm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_ok     (cfg_ok),
    .cfg_fail   (cfg_fail),
    .reloc_done (reloc_done),
    .arm_nx     (arm_nx),
    .arm_q      (arm_q)
  );

  irq_pin_steer #(.NUM_PINS(NUM_PINS)) u_steer (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_in    (sel_in),
    .sel_wr    (sel_wr),
    .arm_nx    (arm_nx),
    .shaped_nx (shaped_nx),
    .pol_hi    (pol_hi),
    .pin       (irq_pin),
    .oe        (irq_oe)
  );

  // R9: all pins float while the arming controller is not live.
  p_float_until_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_q |-> (irq_oe == '0));

  // R3: once live, exactly one pin is driven.
  p_one_driven_r3: assert property (@(posedge clk) disable iff (!rst_n)
    arm_q |-> ($countones(irq_oe) == 1));

endmodule

// File: tb/tb_irq_pin_router.sv
module tb_irq_pin_router;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] stat_a, stat_b, mask_a, mask_b;
  logic [1:0]  sel_in;
  logic        sel_wr, pol_hi, edge_mode, cfg_ok, cfg_fail, reloc_done;
  logic [3:0]  irq_pin, irq_oe;

  always #5 clk = ~clk;

  irq_pin_router dut (
    .clk(clk), .rst_n(rst_n), .stat_a(stat_a), .stat_b(stat_b),
    .mask_a(mask_a), .mask_b(mask_b), .sel_in(sel_in), .sel_wr(sel_wr),
    .pol_hi(pol_hi), .edge_mode(edge_mode), .cfg_ok(cfg_ok),
    .cfg_fail(cfg_fail), .reloc_done(reloc_done),
    .irq_pin(irq_pin), .irq_oe(irq_oe)
  );

  // Source positions from R1.
  localparam logic [15:0] SRC_A = 16'h5D00;
  localparam logic [15:0] SRC_B = 16'h022A;

  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;
  bit   m_arm, m_fail, m_prev;
  logic [1:0] m_sel;
  logic [3:0] e_pin, e_oe;

  task automatic compare(input string tag);
    n_chk++;
    if (irq_pin !== e_pin || irq_oe !== e_oe) begin
      n_bad++;
      $display("FAIL %s: pin=%b oe=%b expected pin=%b oe=%b",
               tag, irq_pin, irq_oe, e_pin, e_oe);
    end
  endtask

  // One clock: update the model from the sampled inputs, compare at negedge.
  task automatic cycle(input string tag);
    logic req, sh;
    @(posedge clk);
    req = (|(stat_a & SRC_A & ~mask_a)) || (|(stat_b & SRC_B & ~mask_b));
    if (!m_arm) begin
      if (cfg_ok)      m_arm = 1'b1;
      else if (m_fail) begin if (reloc_done) m_arm = 1'b1; end
      else if (cfg_fail) m_fail = 1'b1;
    end
    if (sel_wr) m_sel = sel_in;
    sh     = req && (!edge_mode || !m_prev);
    m_prev = req;
    e_oe   = m_arm ? (4'b0001 << m_sel) : 4'b0000;
    e_pin  = {4{~pol_hi}};
    if (m_arm && sh) e_pin[m_sel] = pol_hi;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cfg_ok = 1'b0; cfg_fail = 1'b0; reloc_done = 1'b0; sel_wr = 1'b0;
    @(posedge clk);
    @(negedge clk);
    m_arm = 1'b0; m_fail = 1'b0; m_prev = 1'b0; m_sel = 2'd0;
    e_pin = 4'b0000; e_oe = 4'b0000;
    compare("R9 R5 reset state");
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    stat_a = '0; stat_b = '0; mask_a = '0; mask_b = '0;
    sel_in = '0; sel_wr = 1'b0; pol_hi = 1'b1; edge_mode = 1'b0;
    cfg_ok = 1'b0; cfg_fail = 1'b0; reloc_done = 1'b0;
    do_reset();

    // R9/R10: recovery path, relocation before failure is ignored.
    stat_a = 16'h4000;
    reloc_done = 1'b1;
    cycle("R10 reloc before fail ignored");
    cycle("R10 reloc before fail ignored");
    reloc_done = 1'b0;
    cycle("R9 still floating");
    cfg_fail = 1'b1;
    cycle("R9 fail keeps floating");
    cfg_fail = 1'b0;
    cycle("R9 floating after fail");
    cycle("R9 floating after fail");
    reloc_done = 1'b1;
    cycle("R9 armed by reloc after fail");
    reloc_done = 1'b0;
    cycle("R4 default pin1 R7 level");

    // R10: strobes after arming change nothing.
    cfg_fail = 1'b1; reloc_done = 1'b1;
    cycle("R10 armed sticky");
    cfg_fail = 1'b0; reloc_done = 1'b0;
    cycle("R10 armed sticky");

    // R9: direct load path, ok beats fail.
    do_reset();
    cycle("R9 float before load");
    cfg_ok = 1'b1; cfg_fail = 1'b1;
    cycle("R9 armed by load ok");
    cfg_ok = 1'b0; cfg_fail = 1'b0;
    stat_a = '0;
    cycle("R7 idle");

    // R1/R2: every bit position of both words, masked and unmasked.
    for (int w = 0; w < 2; w++) begin
      for (int b = 0; b < 16; b++) begin
        for (int m = 0; m < 3; m++) begin
          logic [15:0] one, mk;
          one = 16'h0001 << b;
          mk  = (m == 1) ? one : ((m == 2) ? ~one : 16'h0000);
          stat_a = (w == 0) ? one : 16'h0000;
          stat_b = (w == 1) ? one : 16'h0000;
          mask_a = (w == 0) ? mk : 16'hFFFF;
          mask_b = (w == 1) ? mk : 16'hFFFF;
          cycle("R1 R2 source sweep");
          stat_a = '0; stat_b = '0;
          cycle("R1 R7 release");
        end
      end
    end
    mask_a = '0; mask_b = '0;

    // R3/R5/R6/R7/R8: pins x polarity x mode under a request pattern.
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 2; p++) begin
        for (int e = 0; e < 2; e++) begin
          logic [11:0] pat;
          pat = 12'b0110_1110_0101;
          sel_in = s[1:0]; sel_wr = 1'b1;
          pol_hi = p[0]; edge_mode = e[0];
          for (int t = 0; t < 12; t++) begin
            stat_a = 16'h00F1 | (pat[t] ? 16'h0100 : 16'h0000);
            cycle("R3 R5 R6 R7 R8 config sweep");
            sel_wr = 1'b0;
          end
        end
      end
    end

    // R4: moving the selection while a request is held (level mode).
    pol_hi = 1'b1; edge_mode = 1'b0; stat_a = '0; stat_b = 16'h0002;
    cycle("R7 held request");
    for (int s = 3; s >= 0; s--) begin
      sel_in = s[1:0]; sel_wr = 1'b1;
      cycle("R4 switch shows current request");
      sel_wr = 1'b0;
      cycle("R4 selection kept");
    end

    // R8: request held high gives one pulse only, even across a selection move.
    edge_mode = 1'b1; stat_b = '0;
    cycle("R8 idle");
    stat_b = 16'h0200;
    cycle("R8 first pulse");
    cycle("R8 held no pulse");
    sel_in = 2'd2; sel_wr = 1'b1;
    cycle("R8 R4 switch while held");
    sel_wr = 1'b0;
    cycle("R8 held no pulse");
    stat_b = '0;
    cycle("R8 release");
    stat_b = 16'h0008;
    cycle("R8 second pulse");
    cycle("R8 held no pulse");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule